// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause-22 MDIO management master driven by four 32-bit registers on a simple write/read register port. Software first loads the PHY address, the PHY register number and the direction into an address register, loads a 16-bit value into a write-data register when the access is a write, and then writes the control register with both the go/busy bit and the enable bit set. The block runs the serial management frame on a split MDIO pin (output, output enable, input) with its own divided MDC clock. It clears the go/busy bit when the frame ends, and for reads it leaves the 16 sampled bits in a read-data register.

The go/busy bit does two jobs: software sets it to start, and hardware holds it at 1 for the whole frame. While it is 1, further go requests are dropped. The MDC half period is derived from the system clock frequency and the highest allowed MDC frequency. It is rounded up, so MDC never runs faster than the limit.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, MDC is low and the MDIO output enable is low.
- R2: The address register (byte offset 0x7E4) keeps bits 10:0 and reads 0 above them. Bits 4:0 are the PHY register number, bits 9:5 the PHY address, and bit 10 the direction (1 = read, 0 = write). The write-data register (0x7E8) keeps bits 15:0 and reads 0 above them.
- R3: Control register (0x7F0) bit 3 is the enable and reads back as written. A control write with bit 0 set starts nothing unless the written bit 3 is also 1.
- R4: A control write with bits 0 and 3 set while idle starts a frame. Control bit 0 then reads 1 for exactly 64 MDC periods and returns to 0 when the frame ends.
- R5: A frame has 64 bits, driven MSB first and changing only while MDC is low. The bits are: 32 ones, start 01, opcode (10 read, 01 write), PHY address, register number, turnaround (10 on a write), then 16 data bits.
- R6: On a read, the output enable goes low for the last 18 bits (turnaround and data). The 16 data bits are sampled from the MDIO input at the rising MDC edges and placed in the read-data register (0x7EC, bits 15:0).
- R7: A read where no PHY drives the pulled-up line returns 0xFFFF.
- R8: The MDC half period is ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)) system clocks (40 at the defaults, giving 2.5 MHz). MDC is low whenever the block is idle.
- R9: A go request written while a frame is running is ignored. The running frame is not restarted or lengthened, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that the MDIO input comes from a pulled-up line. They also assume that the register port writes only one register per cycle, so that the address register is never being rewritten in the same cycle a frame starts. The stimulus writes one register per cycle on falling clock edges, and it models the pull-up plus a PHY that drives read data only while the master has released the line. Software waits for busy to clear before it starts the next access, and the only exception is the deliberate mid-frame go request used to exercise R9.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int SYS_CLK_HZ = 200_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] OFS_ADDR = 12'h7E4,
  parameter logic [ADDR_W-1:0] OFS_WDAT = 12'h7E8,
  parameter logic [ADDR_W-1:0] OFS_RDAT = 12'h7EC,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h7F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF   = (SYS_CLK_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ);
  localparam int CW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NBITS  = 64;
  localparam int BW     = $clog2(NBITS);
  localparam int REL_AT = 46;
  localparam int DAT_AT = 48;

  logic [10:0]     addr_q;
  logic [15:0]     wdat_q, rdat_q, cap_q;
  logic            en_q, busy_q, mdc_q, rd_q;
  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   bitn_q;
  logic [NBITS-1:0] sh_q;

  wire ctrl_wr  = bus_wr && bus_addr == OFS_CTRL;
  wire go       = ctrl_wr && bus_wdata[0] && bus_wdata[3] && !busy_q;
  wire tick     = busy_q && cnt_q == CW'(HALF-1);
  wire last_bit = bitn_q == BW'(NBITS-1);
  wire rd_new   = addr_q[10];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; wdat_q <= '0; rdat_q <= '0; cap_q <= '0;
      en_q <= 1'b0; busy_q <= 1'b0; mdc_q <= 1'b0; rd_q <= 1'b0;
      cnt_q <= '0; bitn_q <= '0; sh_q <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_ADDR) addr_q <= bus_wdata[10:0];
      if (bus_wr && bus_addr == OFS_WDAT) wdat_q <= bus_wdata[15:0];
      if (ctrl_wr) en_q <= bus_wdata[3];
      if (go) begin
        busy_q <= 1'b1;
        rd_q   <= rd_new;
        cnt_q  <= '0;
        bitn_q <= '0;
        mdc_q  <= 1'b0;
        sh_q   <= {32'hFFFF_FFFF, 2'b01, rd_new ? 2'b10 : 2'b01,
                   addr_q[9:5], addr_q[4:0],
                   rd_new ? 2'b11 : 2'b10,
                   rd_new ? 16'hFFFF : wdat_q};
      end else if (tick) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (rd_q && bitn_q >= BW'(DAT_AT)) cap_q <= {cap_q[14:0], mdio_i};
        end else if (last_bit) begin
          busy_q <= 1'b0;
          if (rd_q) rdat_q <= cap_q;
        end else begin
          bitn_q <= bitn_q + 1'b1;
          sh_q   <= {sh_q[NBITS-2:0], 1'b1};
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[NBITS-1];
  assign mdio_oe = busy_q && !(rd_q && bitn_q >= BW'(REL_AT));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_ADDR) bus_rdata = {21'd0, addr_q};
    if (bus_addr == OFS_WDAT) bus_rdata = {16'd0, wdat_q};
    if (bus_addr == OFS_RDAT) bus_rdata = {16'd0, rdat_q};
    if (bus_addr == OFS_CTRL) bus_rdata = {28'd0, en_q, 2'b00, busy_q};
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_start_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> en_q);

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (bitn_q >= $past(bitn_q)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && bitn_q >= BW'(REL_AT)) |-> !mdio_oe);

  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(bitn_q) == BW'(NBITS-1) && !mdc));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int HALF = 40;
  localparam logic [11:0] A_ADDR = 12'h7E4, A_WDAT = 12'h7E8,
                          A_RDAT = 12'h7EC, A_CTRL = 12'h7F0;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = A_CTRL;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_on = 1'b0;
  logic [15:0] phy_word = '0;
  int mon_n = 0;
  logic [63:0] got_f = '0, got_oe = '0;
  logic [63:0] q_f[$], q_oe[$];
  int tests = 0, fails = 0, frames_seen = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mdio_master dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = mdio_oe ? mdio_o :
                  (phy_on && mon_n >= 48 && mon_n < 64) ? phy_word[63-mon_n] : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge mdc) begin
    got_f  = {got_f[62:0], mdio_o};
    got_oe = {got_oe[62:0], mdio_oe};
    mon_n++;
    if (mon_n == 64) begin
      logic [63:0] ef, eo;
      mon_n = 0;
      frames_seen++;
      if (q_f.size() == 0) begin
        chk(0, "R9 unexpected frame", got_f, 64'd0);
      end else begin
        ef = q_f.pop_front();
        eo = q_oe.pop_front();
        chk(got_oe == eo, "R6 output enable pattern", got_oe, eo);
        chk((got_f & eo) == (ef & eo), "R5 frame bits", got_f & eo, ef & eo);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = A_CTRL;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_addr = A_CTRL;
  endtask

  task automatic xfer(input bit is_rd, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] wd, input bit drive, input logic [15:0] pv,
                      input bit glitch);
    logic [63:0] f, oe;
    logic [31:0] v;
    int n;
    f  = {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01, pa, ra, 2'b10, wd};
    oe = is_rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    q_f.push_back(f); q_oe.push_back(oe);
    phy_on = drive; phy_word = pv;
    wr(A_ADDR, {21'd0, is_rd, pa, ra});
    wr(A_WDAT, {16'hDEAD, wd});
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h9;
    n = 0;
    forever begin
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = A_CTRL;
      if (glitch && n == 1000) begin bus_wr = 1'b1; bus_wdata = 32'h9; end
      if (glitch && n == 1001) begin bus_wr = 1'b1; bus_addr = A_ADDR; bus_wdata = 32'h3FF; end
      #1;
      if (bus_addr == A_CTRL && !bus_rdata[0]) break;
      n++;
      if (n > 8000) break;
    end
    bus_wr = 1'b0; bus_addr = A_CTRL;
    chk(n == 64*2*HALF, "R4 R8 busy length in clocks", 64'(n), 64'(64*2*HALF));
    if (is_rd) begin
      rd(A_RDAT, v);
      chk(v == {16'd0, drive ? pv : 16'hFFFF}, drive ? "R6 read data" : "R7 undriven read",
          64'(v), 64'({16'd0, drive ? pv : 16'hFFFF}));
    end
    repeat (4) @(negedge clk);
    chk(q_f.size() == 0, "R5 frame observed", 64'(q_f.size()), 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    int fr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_ADDR, v); chk(v == 0, "R1 addr reset", 64'(v), 64'd0);
    rd(A_WDAT, v); chk(v == 0, "R1 wdata reset", 64'(v), 64'd0);
    rd(A_RDAT, v); chk(v == 0, "R1 rdata reset", 64'(v), 64'd0);
    rd(A_CTRL, v); chk(v == 0, "R1 ctrl reset", 64'(v), 64'd0);
    chk(!mdc && !mdio_oe, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);

    wr(A_ADDR, 32'hFFFF_FFFF); rd(A_ADDR, v); chk(v == 32'h7FF, "R2 addr mask", 64'(v), 64'h7FF);
    wr(A_WDAT, 32'hFFFF_FFFF); rd(A_WDAT, v); chk(v == 32'hFFFF, "R2 wdata mask", 64'(v), 64'hFFFF);
    wr(A_CTRL, 32'h8); rd(A_CTRL, v); chk(v == 32'h8, "R3 enable readback", 64'(v), 64'h8);

    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); chk(v == 32'h0, "R3 go without enable", 64'(v), 64'h0);
    repeat (200) @(negedge clk);
    chk(!mdc && !mdio_oe && frames_seen == 0, "R3 no frame when disabled",
        {62'd0, mdc, mdio_oe}, 64'd0);

    xfer(1'b0, 5'd5, 5'd17, 16'hA5C3, 1'b0, 16'h0, 1'b0);
    xfer(1'b1, 5'd1, 5'd2, 16'h0, 1'b1, 16'h1234, 1'b0);
    xfer(1'b1, 5'd31, 5'd31, 16'h0, 1'b0, 16'h0, 1'b0);
    fr = frames_seen;
    xfer(1'b0, 5'd31, 5'd0, 16'h0001, 1'b0, 16'h0, 1'b1);
    repeat (3000) @(negedge clk);
    chk(frames_seen == fr + 1, "R9 single frame after mid-frame go", 64'(frames_seen), 64'(fr + 1));
    chk(!mdc && !mdio_oe, "R8 idle after frames", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(A_CTRL, v); chk(v == 32'h8, "R9 busy clear after ignored go", 64'(v), 64'h8);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule